// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers up to 32 interrupt lines and drives two request outputs toward a processor: a fast request and a normal request. Source 0 is the external fast-interrupt pin. It feeds only the fast request. Sources 1 to 4 are external request pins, and the remaining sources are on-chip peripheral lines. Each source has its own enable, a 3-bit priority, a trigger mode and a vector. A polarity bit is kept only for the external sources (0 to 4).

Software reads the vector register to acknowledge the winning normal source. That read returns the source's vector, clears its edge latch, and pushes the source's priority onto a nesting stack. From then on, only sources of strictly higher priority raise the normal request. A write to the end-of-interrupt register pops the stack. A separate fast-vector read services source 0.

The register port is a plain strobe interface with no back-pressure. A read issued in cycle T returns `rd_valid_o` and `rd_data_o` in cycle T+1. A write takes effect at the clock edge that samples it.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, both request outputs are low, every source is disabled with configuration reading 0, and the nesting stack is empty.
- R2: A source whose enable bit is 0 never raises the normal request and is never acknowledged.
- R3: The fast request is high exactly when source 0 is enabled and pending. Source 0 never takes part in normal arbitration.
- R4: Sources 5 to 31 accept level mode (pending while the input is high) or edge mode (latched on a rising edge). Their polarity bit is ignored and reads back as 0.
- R5: Sources 0 to 4 offer four trigger modes, selected by the edge bit and the polarity bit: rising edge, falling edge, high level and low level. The polarity bit reads back as written.
- R6: A read of the vector register returns the vector of the enabled, pending normal source with the highest priority. Among equal priorities, the lower source number wins.
- R7: An acknowledge clears the source's edge latch. An edge that arrives in the same cycle as the acknowledge keeps the source pending. A level source stays pending while its input is active.
- R8: After an acknowledge, only sources of strictly higher priority than the top of the stack raise the normal request. Nesting reaches up to 8 levels.
- R9: A write to end-of-interrupt pops one stack level. On an empty stack, the write has no effect.
- R10: When no normal source qualifies, a vector read returns the spurious vector and leaves the stack unchanged.
- R11: A read of the fast-vector register returns source 0's vector, clears source 0's edge latch, and leaves the stack unchanged.
- R12: The register address is {page[1:0], index[4:0]}.
  - Page 0 holds per-source configuration: bits [2:0] priority, bit 3 edge, bit 4 polarity (falling or low when set), bit 5 enable.
  - Page 1 holds per-source vectors.
  - Page 2 holds the control registers: index 0 vector/acknowledge, 1 end-of-interrupt, 2 spurious vector, 3 fast vector.
  - Read data appears with `rd_valid_o` exactly one cycle after the read strobe.
  - Pending state is registered, so the request outputs follow an input change one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 32 | Interrupt source inputs, bit 0 is the fast pin |
| reg_en_i | input | 1 | Register access strobe |
| reg_wr_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 7 | {page, index} register address |
| reg_wdata_i | input | 16 | Write data |
| rd_valid_o | output | 1 | Read data valid, one cycle after a read strobe |
| rd_data_o | output | 16 | Read data |
| irq_req_o | output | 1 | Normal interrupt request |
| fiq_req_o | output | 1 | Fast interrupt request |

## Verification
Two functions can land in the same cycle: an acknowledge clearing a source's edge latch, and a fresh edge arriving on that same source. The bench provokes this by raising the input in exactly the cycle of the vector read. It then judges the outcome after an end-of-interrupt: the normal request must come back, and a second read must return the same vector. A behavioural model built on queues predicts the request lines and read data on every cycle, and it is compared against both the nesting sequences and these collisions.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  typedef enum logic [1:0] {
    PG_CFG  = 2'd0,
    PG_VEC  = 2'd1,
    PG_CTL  = 2'd2,
    PG_NONE = 2'd3
  } page_e;

  localparam int CTL_VECTOR = 0;
  localparam int CTL_EOI    = 1;
  localparam int CTL_SPUR   = 2;
  localparam int CTL_FAST   = 3;
endpackage

// File: rtl/irq_src_cond.sv
module irq_src_cond #(
  parameter bit HAS_POL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  input  logic edge_mode_i,
  input  logic invert_i,
  input  logic clr_i,
  output logic pend_o
);
  logic raw_q;
  logic pend_q;
  logic inv_eff;
  logic active;
  logic edge_hit;

  // internal sources have no polarity choice
  assign inv_eff  = HAS_POL ? invert_i : 1'b0;
  assign active   = raw_i ^ inv_eff;
  assign edge_hit = inv_eff ? (raw_q & ~raw_i) : (~raw_q & raw_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      raw_q <= raw_i;
      if (!edge_mode_i) begin
        pend_q <= active;
      end else if (edge_hit) begin
        pend_q <= 1'b1;          // a new edge wins over a same-cycle clear
      end else if (clr_i) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign pend_o = pend_q;

  AST_EDGE_NOT_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode_i && edge_hit) |=> pend_o); // R7
  AST_ACK_CLEARS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode_i && clr_i && !edge_hit) |=> !pend_o); // R7
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 3,
  parameter int IDX_W  = 5
) (
  input  logic [NSRC-1:0]        cand_i,
  input  logic [NSRC*PRIO_W-1:0] prio_i,
  input  logic                   floor_vld_i,
  input  logic [PRIO_W-1:0]      floor_i,
  output logic                   win_vld_o,
  output logic [IDX_W-1:0]       win_idx_o,
  output logic [PRIO_W-1:0]      win_prio_o
);
  logic [PRIO_W-1:0] p;
  logic              above;

  // linear scan: strict compare keeps the lowest index on a tie
  always_comb begin
    win_vld_o  = 1'b0;
    win_idx_o  = '0;
    win_prio_o = '0;
    p          = '0;
    above      = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      p     = prio_i[i*PRIO_W +: PRIO_W];
      above = !floor_vld_i || (p > floor_i);
      if (cand_i[i] && above && (!win_vld_o || (p > win_prio_o))) begin
        win_vld_o  = 1'b1;
        win_idx_o  = IDX_W'(i);
        win_prio_o = p;
      end
    end
  end
endmodule

// File: rtl/irq_prio_stack.sv
module irq_prio_stack #(
  parameter int DEPTH  = 8,
  parameter int PRIO_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [PRIO_W-1:0] push_prio_i,
  input  logic              pop_i,
  output logic              top_vld_o,
  output logic [PRIO_W-1:0] top_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PRIO_W-1:0] mem_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q;
  logic              full;

  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign top_vld_o = (cnt_q != '0);
  assign top_o     = top_vld_o ? mem_q[PTR_W'(cnt_q - 1'b1)] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i && !full) begin
      mem_q[PTR_W'(cnt_q)] <= push_prio_i;
      cnt_q                <= cnt_q + 1'b1;
    end else if (pop_i && top_vld_o) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full); // R8
  AST_NEST_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && top_vld_o) |=> (top_o > $past(top_o))); // R8
  AST_EMPTY_POP_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !top_vld_o) |=> !top_vld_o); // R9
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int NSRC    = 32,
  parameter int NUM_EXT = 5,
  parameter int PRIO_W  = 3,
  parameter int DATA_W  = 16,
  localparam int IDX_W  = $clog2(NSRC),
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_i,
  input  logic              reg_en_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_req_o,
  output logic              fiq_req_o
);
  localparam int STACK_DEPTH = 1 << PRIO_W;
  localparam int CFG_W       = PRIO_W + 3;
  localparam int B_EDGE      = PRIO_W;
  localparam int B_INV       = PRIO_W + 1;
  localparam int B_EN        = PRIO_W + 2;

  page_e             page;
  logic [IDX_W-1:0]  idx;
  logic              rd_stb, wr_stb, ctl_rd, ctl_wr;
  logic              vec_ack, fast_ack, eoi, push;

  logic [NSRC-1:0]        src_en, src_edge, src_inv, src_pend, src_clr, cand;
  logic [NSRC*PRIO_W-1:0] src_prio;
  logic [DATA_W-1:0]      src_vec [NSRC];
  logic [DATA_W-1:0]      spur_q;

  logic              win_vld;
  logic [IDX_W-1:0]  win_idx;
  logic [PRIO_W-1:0] win_prio;
  logic              stk_vld;
  logic [PRIO_W-1:0] stk_top;

  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rd_data_q;
  logic              rd_valid_q;

  // access decode
  assign page     = page_e'(reg_addr_i[ADDR_W-1 -: 2]);
  assign idx      = reg_addr_i[IDX_W-1:0];
  assign rd_stb   = reg_en_i && !reg_wr_i;
  assign wr_stb   = reg_en_i && reg_wr_i;
  assign ctl_rd   = rd_stb && (page == PG_CTL);
  assign ctl_wr   = wr_stb && (page == PG_CTL);
  assign vec_ack  = ctl_rd && (idx == IDX_W'(CTL_VECTOR));
  assign fast_ack = ctl_rd && (idx == IDX_W'(CTL_FAST));
  assign eoi      = ctl_wr && (idx == IDX_W'(CTL_EOI));
  assign push     = vec_ack && win_vld;

  // per-source configuration and trigger conditioning
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    localparam bit EXT = (g < NUM_EXT);
    logic              hit;
    logic              en_q, edge_q, inv_q;
    logic [PRIO_W-1:0] prio_q;
    logic [DATA_W-1:0] vec_q;

    assign hit = wr_stb && (idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q   <= 1'b0;
        edge_q <= 1'b0;
        inv_q  <= 1'b0;
        prio_q <= '0;
        vec_q  <= '0;
      end else if (hit && (page == PG_CFG)) begin
        prio_q <= reg_wdata_i[PRIO_W-1:0];
        edge_q <= reg_wdata_i[B_EDGE];
        inv_q  <= EXT ? reg_wdata_i[B_INV] : 1'b0;
        en_q   <= reg_wdata_i[B_EN];
      end else if (hit && (page == PG_VEC)) begin
        vec_q <= reg_wdata_i;
      end
    end

    assign src_en[g]                      = en_q;
    assign src_edge[g]                    = edge_q;
    assign src_inv[g]                     = inv_q;
    assign src_prio[g*PRIO_W +: PRIO_W]   = prio_q;
    assign src_vec[g]                     = vec_q;
    assign src_clr[g] = (push && (win_idx == IDX_W'(g))) || (fast_ack && (g == 0));

    irq_src_cond #(.HAS_POL(EXT)) u_cond (
      .clk         (clk),
      .rst_n       (rst_n),
      .raw_i       (irq_i[g]),
      .edge_mode_i (edge_q),
      .invert_i    (inv_q),
      .clr_i       (src_clr[g]),
      .pend_o      (src_pend[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spur_q <= '0;
    end else if (ctl_wr && (idx == IDX_W'(CTL_SPUR))) begin
      spur_q <= reg_wdata_i;
    end
  end

  // source 0 belongs to the fast line only
  assign cand = src_pend & src_en & {{(NSRC-1){1'b1}}, 1'b0};

  irq_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
    .cand_i      (cand),
    .prio_i      (src_prio),
    .floor_vld_i (stk_vld),
    .floor_i     (stk_top),
    .win_vld_o   (win_vld),
    .win_idx_o   (win_idx),
    .win_prio_o  (win_prio)
  );

  irq_prio_stack #(.DEPTH(STACK_DEPTH), .PRIO_W(PRIO_W)) u_stack (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push),
    .push_prio_i (win_prio),
    .pop_i       (eoi),
    .top_vld_o   (stk_vld),
    .top_o       (stk_top)
  );

  // read data selection
  always_comb begin
    rd_mux = '0;
    unique case (page)
      PG_CFG: rd_mux[CFG_W-1:0] = {src_en[idx], src_inv[idx], src_edge[idx],
                                   src_prio[int'(idx)*PRIO_W +: PRIO_W]};
      PG_VEC: rd_mux = src_vec[idx];
      PG_CTL: begin
        if (idx == IDX_W'(CTL_VECTOR))    rd_mux = win_vld ? src_vec[win_idx] : spur_q;
        else if (idx == IDX_W'(CTL_SPUR)) rd_mux = spur_q;
        else if (idx == IDX_W'(CTL_FAST)) rd_mux = src_vec[0];
        else                              rd_mux = '0;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_stb;
      if (rd_stb) rd_data_q <= rd_mux;
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;
  assign irq_req_o  = win_vld;
  assign fiq_req_o  = src_pend[0] & src_en[0];

  AST_ACK_ABOVE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!stk_vld || (win_prio > stk_top))); // R8
  AST_ACK_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> src_en[win_idx]); // R2
  AST_SRC0_NOT_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (win_idx != '0)); // R3
  AST_SPUR_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_ack && !win_vld) |=> ($stable(stk_vld) && $stable(stk_top))); // R10
  AST_FAST_NO_STACK: assert property (@(posedge clk) disable iff (!rst_n)
    fast_ack |=> ($stable(stk_vld) && $stable(stk_top))); // R11
  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> $past(rd_stb)); // R12
endmodule

// File: tb/irq_vec_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vec_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq = '0;
  logic        reg_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic        irq_req;
  logic        fiq_req;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  irq_vec_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .reg_en_i(reg_en), .reg_wr_i(reg_wr),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .rd_valid_o(rd_valid),
    .rd_data_o(rd_data), .irq_req_o(irq_req), .fiq_req_o(fiq_req)
  );

  // ---------------- behavioural reference ----------------
  logic [2:0]  m_prio [32];
  bit          m_edge [32];
  bit          m_inv  [32];
  bit          m_en   [32];
  bit          m_pend [32];
  bit          m_prev [32];
  logic [15:0] m_vec  [32];
  logic [15:0] m_spur;
  int          stk [$];
  bit          m_rv;
  logic [15:0] m_rd;

  function automatic int m_best();
    int b;
    int bp;
    b  = -1;
    bp = -1;
    for (int i = 1; i < 32; i++)
      if (m_en[i] && m_pend[i] && (stk.size() == 0 || int'(m_prio[i]) > stk[$])
          && int'(m_prio[i]) > bp) begin
        b  = i;
        bp = int'(m_prio[i]);
      end
    return b;
  endfunction

  always @(posedge clk) begin : model
    int        best;
    int        pg;
    int        ix;
    bit [31:0] clr;
    bit        hit;
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) begin
        m_prio[i] = '0; m_edge[i] = 0; m_inv[i] = 0; m_en[i] = 0;
        m_pend[i] = 0;  m_prev[i] = 0; m_vec[i] = '0;
      end
      m_spur = '0;
      stk.delete();
      m_rv = 0;
      m_rd = '0;
    end else begin
      best = m_best();
      pg   = int'(reg_addr[6:5]);
      ix   = int'(reg_addr[4:0]);
      clr  = '0;
      m_rv = 0;
      if (reg_en && !reg_wr) begin
        m_rv = 1;
        m_rd = '0;
        if (pg == 0) m_rd = {10'd0, m_en[ix], m_inv[ix], m_edge[ix], m_prio[ix]};
        else if (pg == 1) m_rd = m_vec[ix];
        else if (pg == 2) begin
          if (ix == 0) begin
            if (best >= 0) begin
              m_rd = m_vec[best];
              clr[best] = 1;
            end else m_rd = m_spur;
          end else if (ix == 2) m_rd = m_spur;
          else if (ix == 3) begin
            m_rd = m_vec[0];
            clr[0] = 1;
          end
        end
      end
      for (int i = 0; i < 32; i++) begin
        if (m_edge[i]) begin
          hit = m_inv[i] ? (m_prev[i] && !irq[i]) : (!m_prev[i] && irq[i]);
          if (hit) m_pend[i] = 1;
          else if (clr[i]) m_pend[i] = 0;
        end else m_pend[i] = irq[i] ^ m_inv[i];
        m_prev[i] = irq[i];
      end
      if (reg_en && !reg_wr && pg == 2 && ix == 0 && best >= 0)
        stk.push_back(int'(m_prio[best]));
      if (reg_en && reg_wr) begin
        if (pg == 0) begin
          m_prio[ix] = reg_wdata[2:0];
          m_edge[ix] = reg_wdata[3];
          m_inv[ix]  = (ix < 5) ? reg_wdata[4] : 1'b0;
          m_en[ix]   = reg_wdata[5];
        end else if (pg == 1) m_vec[ix] = reg_wdata;
        else if (pg == 2 && ix == 1) begin
          if (stk.size() > 0) void'(stk.pop_back());
        end else if (pg == 2 && ix == 2) m_spur = reg_wdata;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 fast request vs model", {31'd0, fiq_req}, {31'd0, m_en[0] && m_pend[0]});
      chk("R8 normal request vs model", {31'd0, irq_req}, {31'd0, m_best() >= 0});
      chk("R12 read valid vs model", {31'd0, rd_valid}, {31'd0, m_rv});
      if (m_rv) chk("R6 read data vs model", {16'd0, rd_data}, {16'd0, m_rd});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int pg, input int ix, input logic [15:0] d);
    @(negedge clk);
    reg_en = 1; reg_wr = 1; reg_addr = {pg[1:0], ix[4:0]}; reg_wdata = d;
    @(negedge clk);
    reg_en = 0; reg_wr = 0;
  endtask

  task automatic rd(input int pg, input int ix, output logic [15:0] d);
    @(negedge clk);
    reg_en = 1; reg_wr = 0; reg_addr = {pg[1:0], ix[4:0]};
    @(negedge clk);
    reg_en = 0;
    chk("R12 read valid one cycle later", {31'd0, rd_valid}, 32'd1);
    d = rd_data;
  endtask

  task automatic pulse(input int i);
    @(negedge clk); irq[i] = 1;
    @(negedge clk); irq[i] = 0;
  endtask

  function automatic logic [15:0] cfg(input bit en, input bit inv, input bit edg, input int p);
    return {10'd0, en, inv, edg, p[2:0]};
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // ---------------- directed sequence ----------------
  initial begin : stim
    logic [15:0] d;
    cyc(5);
    rst_n = 1;
    cyc(1);
    chk("R1 normal request low after reset", {31'd0, irq_req}, 32'd0);
    chk("R1 fast request low after reset", {31'd0, fiq_req}, 32'd0);
    rd(0, 7, d); chk("R1 config reset value", {16'd0, d}, 32'd0);

    for (int i = 0; i < 32; i++) wr(1, i, 16'h0100 + 16'(i));
    wr(2, 2, 16'hDEAD);
    rd(2, 2, d); chk("R12 spurious register readback", {16'd0, d}, 32'h0000DEAD);

    // R2 masking
    wr(0, 10, cfg(0, 0, 0, 2));
    irq[10] = 1; cyc(3);
    chk("R2 disabled source quiet", {31'd0, irq_req}, 32'd0);
    wr(0, 10, cfg(1, 0, 0, 2)); cyc(2);
    chk("R2 enabled source requests", {31'd0, irq_req}, 32'd1);
    rd(2, 0, d); chk("R6 vector of level source", {16'd0, d}, 32'h010A);
    chk("R8 same level masked after ack", {31'd0, irq_req}, 32'd0);
    wr(2, 1, 16'd0);
    chk("R7 level stays pending after EOI (R9 pop)", {31'd0, irq_req}, 32'd1);
    rd(2, 0, d); chk("R7 level acknowledged again", {16'd0, d}, 32'h010A);
    wr(2, 1, 16'd0);
    irq[10] = 0; cyc(2);
    chk("R7 level drops with input", {31'd0, irq_req}, 32'd0);
    wr(0, 10, cfg(0, 0, 0, 2));

    // R6 tie, internal edge
    wr(0, 12, cfg(1, 0, 1, 5));
    wr(0, 20, cfg(1, 0, 1, 5));
    @(negedge clk); irq[12] = 1; irq[20] = 1;
    @(negedge clk); irq[12] = 0; irq[20] = 0;
    cyc(1);
    chk("R4 internal edge pends", {31'd0, irq_req}, 32'd1);
    rd(2, 0, d); chk("R6 tie goes to lower number", {16'd0, d}, 32'h010C);
    chk("R8 equal priority held off", {31'd0, irq_req}, 32'd0);
    wr(2, 1, 16'd0);
    chk("R9 EOI releases equal priority", {31'd0, irq_req}, 32'd1);
    rd(2, 0, d); chk("R6 second of tie", {16'd0, d}, 32'h0114);
    wr(2, 1, 16'd0);
    chk("R7 edge latch cleared by ack", {31'd0, irq_req}, 32'd0);

    // R7 collision: edge in the acknowledge cycle
    pulse(12); cyc(1);
    @(negedge clk); reg_en = 1; reg_wr = 0; reg_addr = {2'd2, 5'd0}; irq[12] = 1;
    @(negedge clk); reg_en = 0; irq[12] = 0;
    chk("R6 vector in collision cycle", {16'd0, rd_data}, 32'h010C);
    chk("R8 held off during collision", {31'd0, irq_req}, 32'd0);
    wr(2, 1, 16'd0);
    chk("R7 edge kept across same-cycle ack", {31'd0, irq_req}, 32'd1);
    rd(2, 0, d); chk("R7 re-acknowledge after collision", {16'd0, d}, 32'h010C);
    wr(2, 1, 16'd0);
    chk("R7 cleared after second ack", {31'd0, irq_req}, 32'd0);

    // R8 nesting
    wr(0, 6,  cfg(1, 0, 1, 1));
    wr(0, 25, cfg(1, 0, 1, 6));
    wr(0, 9,  cfg(1, 0, 1, 4));
    wr(0, 17, cfg(1, 0, 1, 0));
    @(negedge clk); irq[6] = 1; irq[25] = 1;
    @(negedge clk); irq[6] = 0; irq[25] = 0;
    rd(2, 0, d); chk("R6 higher priority beats lower number", {16'd0, d}, 32'h0119);
    chk("R8 lower priority held", {31'd0, irq_req}, 32'd0);
    wr(2, 1, 16'd0);
    rd(2, 0, d); chk("R6 remaining source", {16'd0, d}, 32'h0106);
    pulse(25); cyc(1);
    chk("R8 higher priority preempts", {31'd0, irq_req}, 32'd1);
    rd(2, 0, d); chk("R8 nested vector", {16'd0, d}, 32'h0119);
    pulse(9); cyc(1);
    chk("R8 middle priority held under level 6", {31'd0, irq_req}, 32'd0);
    wr(2, 1, 16'd0);
    chk("R9 pop exposes middle priority", {31'd0, irq_req}, 32'd1);
    rd(2, 0, d); chk("R8 nested third level", {16'd0, d}, 32'h0109);
    wr(2, 1, 16'd0);
    wr(2, 1, 16'd0);
    chk("R9 all levels popped", {31'd0, irq_req}, 32'd0);
    wr(2, 1, 16'd0);
    pulse(17); cyc(1);
    chk("R9 empty-stack EOI harmless, prio 0 requests", {31'd0, irq_req}, 32'd1);
    rd(2, 0, d); chk("R6 priority 0 vector", {16'd0, d}, 32'h0111);
    wr(2, 1, 16'd0);

    // R10 spurious
    rd(2, 0, d); chk("R10 spurious vector", {16'd0, d}, 32'h0000DEAD);
    pulse(17); cyc(1);
    chk("R10 no push on spurious", {31'd0, irq_req}, 32'd1);
    rd(2, 0, d); wr(2, 1, 16'd0);

    // R3 / R11 fast line
    wr(0, 0, cfg(1, 0, 1, 7));
    pulse(0); cyc(1);
    chk("R3 fast pin drives fast request", {31'd0, fiq_req}, 32'd1);
    chk("R3 fast pin not on normal line", {31'd0, irq_req}, 32'd0);
    rd(2, 0, d); chk("R3 source 0 not arbitrated", {16'd0, d}, 32'h0000DEAD);
    rd(2, 3, d); chk("R11 fast vector", {16'd0, d}, 32'h0100);
    chk("R11 fast latch cleared", {31'd0, fiq_req}, 32'd0);
    pulse(17); cyc(1);
    chk("R11 stack untouched by fast read", {31'd0, irq_req}, 32'd1);
    rd(2, 0, d); wr(2, 1, 16'd0);

    // R5 external modes
    wr(0, 2, cfg(1, 1, 1, 3));
    irq[2] = 1; cyc(2);
    chk("R5 falling mode ignores rise", {31'd0, irq_req}, 32'd0);
    irq[2] = 0; cyc(2);
    chk("R5 falling edge pends", {31'd0, irq_req}, 32'd1);
    rd(2, 0, d); chk("R5 falling vector", {16'd0, d}, 32'h0102);
    wr(2, 1, 16'd0);
    wr(0, 1, cfg(1, 0, 1, 2));
    pulse(1); cyc(1);
    rd(2, 0, d); chk("R5 rising vector", {16'd0, d}, 32'h0101);
    wr(2, 1, 16'd0);
    irq[3] = 1;
    wr(0, 3, cfg(1, 1, 0, 4)); cyc(2);
    chk("R5 low level idle when high", {31'd0, irq_req}, 32'd0);
    irq[3] = 0; cyc(2);
    chk("R5 low level pends", {31'd0, irq_req}, 32'd1);
    rd(2, 0, d); chk("R5 low level vector", {16'd0, d}, 32'h0103);
    rd(0, 3, d); chk("R5 external polarity reads back", {16'd0, d}, 32'h0034);
    wr(2, 1, 16'd0);
    irq[3] = 1; cyc(2);
    chk("R5 low level released", {31'd0, irq_req}, 32'd0);
    wr(0, 4, cfg(1, 0, 0, 2));
    irq[4] = 1; cyc(2);
    rd(2, 0, d); chk("R5 high level vector", {16'd0, d}, 32'h0104);
    irq[4] = 0;
    wr(2, 1, 16'd0); cyc(1);

    // R4 internal polarity ignored
    wr(0, 15, cfg(1, 1, 0, 3));
    rd(0, 15, d); chk("R4 internal polarity reads 0", {16'd0, d}, 32'h0023);
    cyc(2);
    chk("R4 inverted setting ignored", {31'd0, irq_req}, 32'd0);
    irq[15] = 1; cyc(2);
    chk("R4 internal high level pends", {31'd0, irq_req}, 32'd1);
    rd(2, 0, d); chk("R4 internal vector", {16'd0, d}, 32'h010F);
    irq[15] = 0;
    wr(2, 1, 16'd0); cyc(2);
    chk("R4 internal level released", {31'd0, irq_req}, 32'd0);

    cyc(3);
    done = 1;
    summary();
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R12 act=timeout exp=completion");
      summary();
      $finish;
    end
  end
endmodule